// File: doc/BRIEF.md
# Routed Level Interrupt Controller

This block collects a set of level-sensitive interrupt requests, lets software enable each one through a mask register, and steers every enabled request to one of several output interrupt lines. Each source owns a small route selector: a selector of zero leaves the source unconnected, and a nonzero selector `k` sends it to output line `k-1`. Each output line is the OR of every enabled, active source routed to it. Because requests are levels, an output stays high for as long as some enabled input routed to it is held high.

Software reaches the block through a plain 32-bit register port. The port carries an address, a write strobe, write data and combinational read data. The registers are an enable mask, a read-only view of the synchronized input levels, and a bank of route registers. Each route register packs the selectors of eight consecutive sources. The bank is stored in reverse order: the route register with the highest address serves the lowest-numbered sources. Each input passes through a two-flop synchronizer and then a status flop. The output lines are registered.

Top module: `irq_route_ctrl`

## Requirements
- R1: After reset the mask register, the status register, all route registers and all output lines read zero.
- R2: Writing offset 0x00 loads the enable mask, where bit n enables source n. Reading 0x00 returns the value written.
- R3: Offset 0x04 returns the synchronized input levels, where bit n is source n, whatever the mask holds. A write to 0x04 changes nothing.
- R4: The route registers at offsets 0x08, 0x0C, 0x10 and 0x14 are fully readable and writable.
- R5: Offset 0x14 holds the selectors of sources 0-7, 0x10 holds sources 8-15, 0x0C holds sources 16-23 and 0x08 holds sources 24-31. Within its register, source s uses bits [4*(s%8)+3 : 4*(s%8)].
- R6: A source whose selector is 0 drives no output line.
- R7: A source that is enabled and active, and whose selector is k in 1..15, drives output line k-1.
- R8: A source whose mask bit is clear drives no output line, even while its input is high.
- R9: Output line j is the OR of all enabled, active sources whose selector is j+1. It falls once those inputs go low.
- R10: Reads from any offset other than those above return zero. Writes to them change no register.
- R11: A rise on an input reaches the output lines on the fourth clock edge: two synchronizer flops, the status flop and the output flop. A mask write reaches the outputs on the edge after the one that stores it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 32 | Level interrupt requests, bit n is source n |
| bus_addr | input | 8 | Byte offset of the register access |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_out | output | 15 | Output interrupt lines, registered levels |

## Verification
The hardest case to reach from the ports is the packing of the route bank. A selector that lands in the wrong register or the wrong nibble would go unnoticed if only one or two sources were tried. The bench therefore holds every input high with every source enabled. It then steps every source through every one of the 16 selector values, one source at a time, and requires exactly the predicted one-hot output, or none. A second sweep loads arithmetic mixes of selectors, masks and input levels so that many sources share the same lines, and compares every line with an OR computed in the bench.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
   // byte offsets of the register bank
   localparam int unsigned IRC_OFS_MASK   = 'h00;
   localparam int unsigned IRC_OFS_STATUS = 'h04;
   localparam int unsigned IRC_OFS_ROUTE0 = 'h08;
   localparam int unsigned IRC_WORD_BYTES = 4;

   // offset of route register number idx
   function automatic int unsigned irc_route_ofs(input int unsigned idx);
      return IRC_OFS_ROUTE0 + IRC_WORD_BYTES * idx;
   endfunction
endpackage

// File: rtl/irc_sync.sv
module irc_sync #(
   parameter int unsigned WIDTH  = 32,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] status_o
);
   localparam int unsigned DEPTH = STAGES + 1; // synchronizer plus status flop

   if (STAGES < 2) begin : g_bad_stages
      $error("irc_sync: STAGES must be at least 2");
   end

   logic [DEPTH-1:0][WIDTH-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '0;
      end else begin
         chain_q[0] <= d_i;
         for (int i = 1; i < DEPTH; i++) begin
            chain_q[i] <= chain_q[i-1];
         end
      end
   end

   assign status_o = chain_q[DEPTH-1];

   // R3: status follows the input one edge after the last synchronizer stage
   assert_status_tracks_R3: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> status_o == $past(chain_q[DEPTH-2]));
endmodule

// File: rtl/irc_regs.sv
module irc_regs
   import irq_route_pkg::*;
#(
   parameter int unsigned N_SRC  = 32,
   parameter int unsigned RW     = 4,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned ADDR_W = 8
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [ADDR_W-1:0]          addr_i,
   input  logic                       we_i,
   input  logic [DATA_W-1:0]          wdata_i,
   input  logic [N_SRC-1:0]           status_i,
   output logic [N_SRC-1:0]           mask_o,
   output logic [N_SRC-1:0][RW-1:0]   route_o,
   output logic [DATA_W-1:0]          rdata_o
);
   localparam int unsigned FPR  = DATA_W / RW;   // selectors per route register
   localparam int unsigned NREG = N_SRC / FPR;   // route registers in the bank
   localparam logic [ADDR_W-1:0] A_MASK   = ADDR_W'(IRC_OFS_MASK);
   localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(IRC_OFS_STATUS);

   if (N_SRC % FPR != 0) begin : g_bad_split
      $error("irc_regs: N_SRC must fill whole route registers");
   end
   if (irc_route_ofs(NREG) > (1 << ADDR_W)) begin : g_bad_addr
      $error("irc_regs: ADDR_W too narrow for the route bank");
   end

   logic [N_SRC-1:0]         mask_q;
   logic [N_SRC-1:0][RW-1:0] route_q;
   logic                     hit_route;

   always_comb begin
      hit_route = 1'b0;
      for (int r = 0; r < NREG; r++) begin
         if (addr_i == ADDR_W'(irc_route_ofs(r))) hit_route = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= '0;
      end else if (we_i && addr_i == A_MASK) begin
         mask_q <= wdata_i[N_SRC-1:0];
      end
   end

   // bank is reversed: register r serves source group NREG-1-r
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         route_q <= '0;
      end else if (we_i) begin
         for (int r = 0; r < NREG; r++) begin
            if (addr_i == ADDR_W'(irc_route_ofs(r))) begin
               for (int f = 0; f < FPR; f++) begin
                  route_q[(NREG-1-r)*FPR + f] <= wdata_i[f*RW +: RW];
               end
            end
         end
      end
   end

   always_comb begin
      rdata_o = '0;
      if (addr_i == A_MASK)   rdata_o[N_SRC-1:0] = mask_q;
      if (addr_i == A_STATUS) rdata_o[N_SRC-1:0] = status_i;
      for (int r = 0; r < NREG; r++) begin
         if (addr_i == ADDR_W'(irc_route_ofs(r))) begin
            for (int f = 0; f < FPR; f++) begin
               rdata_o[f*RW +: RW] = route_q[(NREG-1-r)*FPR + f];
            end
         end
      end
   end

   assign mask_o  = mask_q;
   assign route_o = route_q;

   // R2: a mask write is visible at the next edge
   assert_mask_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (we_i && addr_i == A_MASK) |=> mask_o == $past(wdata_i[N_SRC-1:0]));
   // R10: writes elsewhere leave the mask alone
   assert_mask_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(we_i && addr_i == A_MASK) |=> $stable(mask_o));
   // R4: route bank only changes on a route write
   assert_route_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(we_i && hit_route) |=> $stable(route_o));
endmodule

// File: rtl/irc_route_or.sv
module irc_route_or #(
   parameter int unsigned N_SRC = 32,
   parameter int unsigned N_OUT = 15,
   parameter int unsigned RW    = 4
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [N_SRC-1:0]         mask_i,
   input  logic [N_SRC-1:0]         status_i,
   input  logic [N_SRC-1:0][RW-1:0] route_i,
   output logic [N_OUT-1:0]         irq_o
);
   logic [N_SRC-1:0] pending;
   logic [N_OUT-1:0] line_d;

   assign pending = mask_i & status_i;

   for (genvar j = 0; j < N_OUT; j++) begin : g_line
      logic [N_SRC-1:0] sel;
      for (genvar s = 0; s < N_SRC; s++) begin : g_src
         assign sel[s] = pending[s] && (route_i[s] == RW'(j + 1));
      end
      assign line_d[j] = |sel;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_o <= '0;
      else        irq_o <= line_d;
   end

   // R8: nothing enabled and active means every line is low next cycle
   assert_idle_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (pending == '0) |=> (irq_o == '0));
   // R9: each raised line needs at least one pending source behind it
   assert_lines_bounded_R9: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> $countones(irq_o) <= $countones($past(pending)));
endmodule

// File: rtl/irq_route_ctrl.sv
module irq_route_ctrl #(
   parameter int unsigned N_SRC       = 32,
   parameter int unsigned N_OUT       = 15,
   parameter int unsigned RW          = 4,
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_SRC-1:0]  irq_in,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic [N_OUT-1:0]  irq_out
);
   localparam int unsigned MAX_LINES = (1 << RW) - 1;

   if (N_OUT > MAX_LINES || N_OUT == 0) begin : g_bad_out
      $error("irq_route_ctrl: N_OUT must be 1..2**RW-1");
   end
   if (N_SRC > DATA_W) begin : g_bad_src
      $error("irq_route_ctrl: N_SRC must fit one data word");
   end
   if (DATA_W % RW != 0) begin : g_bad_rw
      $error("irq_route_ctrl: RW must divide DATA_W");
   end

   logic [N_SRC-1:0]         status;
   logic [N_SRC-1:0]         mask;
   logic [N_SRC-1:0][RW-1:0] route;

   irc_sync #(.WIDTH(N_SRC), .STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .d_i      (irq_in),
      .status_o (status)
   );

   irc_regs #(.N_SRC(N_SRC), .RW(RW), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .addr_i   (bus_addr),
      .we_i     (bus_we),
      .wdata_i  (bus_wdata),
      .status_i (status),
      .mask_o   (mask),
      .route_o  (route),
      .rdata_o  (bus_rdata)
   );

   irc_route_or #(.N_SRC(N_SRC), .N_OUT(N_OUT), .RW(RW)) u_or (
      .clk      (clk),
      .rst_n    (rst_n),
      .mask_i   (mask),
      .status_i (status),
      .route_i  (route),
      .irq_o    (irq_out)
   );

   // R8: a line can only be high if the mask had some bit set a cycle earlier
   assert_mask_gates_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_out != '0) |-> ($past(mask) != '0));
endmodule

// File: tb/sim_irq_route_ctrl.sv
module sim_irq_route_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] irq_in = '0;
   logic [7:0]  bus_addr = '0;
   logic        bus_we = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [14:0] irq_out;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;
   logic [3:0] sel_m [32]; // bench model of the selectors

   always #5 clk = ~clk;

   irq_route_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_addr(bus_addr),
      .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq_out(irq_out)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_we = 1'b0;
      #1 d = bus_rdata;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   // register offset holding source s: reversed bank
   function automatic logic [7:0] reg_of(input int s);
      return 8'(8'h08 + 4 * (3 - s / 8));
   endfunction

   function automatic logic [31:0] pack_reg(input int r);
      logic [31:0] v = '0;
      for (int f = 0; f < 8; f++) v[f*4 +: 4] = sel_m[(3 - r) * 8 + f];
      return v;
   endfunction

   function automatic logic [14:0] model(input logic [31:0] m, input logic [31:0] x);
      logic [14:0] o = '0;
      for (int s = 0; s < 32; s++) begin
         if (m[s] && x[s] && sel_m[s] != 4'd0) o[sel_m[s] - 1] = 1'b1;
      end
      return o;
   endfunction

   initial begin
      #(1_500_000 * 10);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      logic [31:0] m, x;
      idle(3);
      // R1: reset state
      rd(8'h00, d); chk("R1 mask", d, 32'h0);
      rd(8'h04, d); chk("R1 status", d, 32'h0);
      for (int r = 0; r < 4; r++) begin
         rd(8'(8'h08 + 4 * r), d); chk("R1 route", d, 32'h0);
      end
      chk("R1 irq_out", {17'h0, irq_out}, 32'h0);
      rst_n = 1'b1;
      idle(2);

      // R2: mask read/write
      wr(8'h00, 32'hA5C3_0F81); rd(8'h00, d); chk("R2 mask a", d, 32'hA5C3_0F81);
      wr(8'h00, 32'hFFFF_FFFF); rd(8'h00, d); chk("R2 mask b", d, 32'hFFFF_FFFF);
      wr(8'h00, 32'h0);         rd(8'h00, d); chk("R2 mask c", d, 32'h0);

      // R3: status shows inputs regardless of mask, writes ignored
      irq_in = 32'h1357_9BDF; idle(4);
      rd(8'h04, d); chk("R3 status unmasked", d, 32'h1357_9BDF);
      wr(8'h04, 32'h0); rd(8'h04, d); chk("R3 status write ignored", d, 32'h1357_9BDF);
      irq_in = '0; idle(4);
      wr(8'h04, 32'hFFFF_FFFF); rd(8'h04, d); chk("R3 status zero", d, 32'h0);

      // R4: route registers read/write
      for (int r = 0; r < 4; r++) wr(8'(8'h08 + 4 * r), 32'h1111_1111 * (r + 3));
      for (int r = 0; r < 4; r++) begin
         rd(8'(8'h08 + 4 * r), d); chk("R4 route rw", d, 32'h1111_1111 * (r + 3));
      end

      // R10: unmapped offsets read zero, writes change nothing
      wr(8'h00, 32'h0F0F_0F0F);
      wr(8'h18, 32'hFFFF_FFFF); wr(8'h02, 32'hFFFF_FFFF); wr(8'hFC, 32'hFFFF_FFFF);
      rd(8'h18, d); chk("R10 read 0x18", d, 32'h0);
      rd(8'h02, d); chk("R10 read 0x02", d, 32'h0);
      rd(8'hFC, d); chk("R10 read 0xFC", d, 32'h0);
      rd(8'h00, d); chk("R10 mask kept", d, 32'h0F0F_0F0F);
      for (int r = 0; r < 4; r++) begin
         rd(8'(8'h08 + 4 * r), d); chk("R10 route kept", d, 32'h1111_1111 * (r + 3));
      end

      // R5 R6 R7: every source through every selector, one at a time
      for (int r = 0; r < 4; r++) wr(8'(8'h08 + 4 * r), 32'h0);
      for (int s = 0; s < 32; s++) sel_m[s] = 4'd0;
      wr(8'h00, 32'hFFFF_FFFF);
      irq_in = 32'hFFFF_FFFF; idle(4);
      chk("R6 all disconnected", {17'h0, irq_out}, 32'h0);
      for (int s = 0; s < 32; s++) begin
         for (int k = 0; k < 16; k++) begin
            wr(reg_of(s), 32'(k) << (4 * (s % 8)));
            idle(1);
            if (k == 0) chk("R6 selector zero", {17'h0, irq_out}, 32'h0);
            else        chk("R5 R7 routed line", {17'h0, irq_out}, 32'h1 << (k - 1));
         end
         // R8: clearing this source's mask bit drops its line
         wr(8'h00, ~(32'h1 << s)); idle(1);
         chk("R8 masked source", {17'h0, irq_out}, 32'h0);
         wr(8'h00, 32'hFFFF_FFFF);
         wr(reg_of(s), 32'h0);
      end

      // R9: mixed selectors, masks and levels against the bench OR model
      for (int i = 0; i < 48; i++) begin
         for (int s = 0; s < 32; s++) sel_m[s] = 4'((s * 7 + i * 3) % 16);
         for (int r = 0; r < 4; r++) wr(8'(8'h08 + 4 * r), pack_reg(r));
         x = 32'h9E37_79B9 * (i + 1);
         m = {x[12:0], x[31:13]} ^ 32'h5A5A_F00F;
         wr(8'h00, m);
         irq_in = x; idle(5);
         chk("R9 mixed OR", {17'h0, irq_out}, {17'h0, model(m, x)});
      end
      // R9: level behaviour, line falls after inputs drop
      for (int s = 0; s < 32; s++) sel_m[s] = 4'd4;
      for (int r = 0; r < 4; r++) wr(8'(8'h08 + 4 * r), 32'h4444_4444);
      wr(8'h00, 32'h0000_FF00);
      irq_in = 32'h0000_1200; idle(5);
      chk("R9 shared line high", {17'h0, irq_out}, 32'h8);
      irq_in = 32'h0000_0200; idle(5);
      chk("R9 one source left", {17'h0, irq_out}, 32'h8);
      irq_in = 32'hFFFF_00FF; idle(5);
      chk("R9 line falls", {17'h0, irq_out}, 32'h0);

      // R11: input to output latency, four edges
      irq_in = '0; idle(5);
      @(negedge clk); irq_in = 32'h0000_0100;
      @(negedge clk); @(negedge clk); @(negedge clk);
      chk("R11 not yet after three edges", {17'h0, irq_out}, 32'h0);
      @(negedge clk);
      chk("R11 high after four edges", {17'h0, irq_out}, 32'h8);
      // R11: mask write latency
      @(negedge clk); bus_addr = 8'h00; bus_wdata = 32'h0; bus_we = 1'b1;
      @(negedge clk); bus_we = 1'b0;
      chk("R11 output one edge after mask store", {17'h0, irq_out}, 32'h8);
      @(negedge clk);
      chk("R11 output follows mask", {17'h0, irq_out}, 32'h0);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule